// File: doc/BRIEF.md
# Banked Video Memory Window Mapper

This block sits between a CPU's byte-wide memory port and a linear video memory. The CPU sees a 64 KiB window that starts at byte address 0xA0000. A bank number selects which 64 KiB slice of video memory shows through that window. When the block is in its 64 KiB window mode, each CPU access has a stored signed offset added to it. The sum is then truncated to the video memory address width, and the access is passed on as a memory read or write strobe.

The offset is recomputed only when the bank number changes. It equals the masked bank shifted left by sixteen, minus the window base, so each access needs one adder and no subtraction. A disable pulse puts the window back to bank zero, and reset does the same.

Addresses at or above 0xB0000 fall outside the window. Writes to them are dropped. Reads of them return 0xFF with the same one-cycle latency as a real memory read.

Top module: `bankwin_mapper`

## Requirements
- R1: After reset the offset is -0xA0000, so CPU address 0xA0000 maps to video address 0, and `cpu_rvalid` is low.
- R2: A cycle with `bank_we` high (and `win_disable` low) sets the offset to (masked bank << 16) - 0xA0000. The new offset applies to accesses from the next cycle on.
- R3: The bank value is ANDed with (VRAM_BYTES / 65536) - 1 before use, so bank numbers beyond the memory size wrap. With the default 1 MiB this mask is 0xF.
- R4: With `map_en` high and an address below 0xB0000, `vm_addr` equals `cpu_addr` plus the offset, truncated to VADDR_W bits, in the same cycle. `vm_wdata` equals `cpu_wdata`.
- R5: With `map_en` high, a read at an address at or above 0xB0000 raises no `vm_rd`. One cycle later it returns `cpu_rdata` = 0xFF with `cpu_rvalid` high.
- R6: With `map_en` high, a write at an address at or above 0xB0000 raises no `vm_wr`.
- R7: With `map_en` high, a read below 0xB0000 raises `vm_rd` in the same cycle. In the next cycle it raises `cpu_rvalid`, and `cpu_rdata` carries `vm_rdata`.
- R8: A cycle with `win_disable` high sets the offset back to -0xA0000 from the next cycle on. It takes priority over a `bank_we` in the same cycle.
- R9: With `map_en` low, the block raises neither memory strobe, and `cpu_rvalid` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_en | input | 1 | 64 KiB window mode active |
| cpu_addr | input | CPU_AW | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | DW | CPU write data |
| bank_val | input | BANK_W | New bank number |
| bank_we | input | 1 | Bank number write strobe |
| win_disable | input | 1 | Restore the window to bank zero |
| vm_addr | output | VADDR_W | Linear video memory address |
| vm_rd | output | 1 | Video memory read enable |
| vm_wr | output | 1 | Video memory write enable |
| vm_wdata | output | DW | Video memory write data |
| vm_rdata | input | DW | Video memory read data, valid one cycle after `vm_rd` |
| cpu_rdata | output | DW | Read data returned to the CPU |
| cpu_rvalid | output | 1 | `cpu_rdata` is valid |

## Verification
The assertions check every cycle for the following:
- Accesses outside the window are gated.
- A read response follows one cycle after each read.
- A blocked read returns 0xFF.
- Strobes stay quiet when the mode is off.
- The mapped address follows the bank number or disable pulse of the previous cycle.

Only the bench's scenarios can show certain behaviours:
- The bank mask wraps bank numbers across the full 0 to 31 sweep.
- The truncated address arithmetic is correct at the window's edges.
- Read data comes through from memory under a modelled memory.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;

  localparam logic [31:0] WIN_BASE = 32'h000A_0000;
  localparam logic [31:0] WIN_LIMIT = 32'h000B_0000;

  // Precomputed signed window offset for a masked bank number.
  function automatic logic [31:0] bank_offset(input logic [31:0] masked_bank);
    return (masked_bank << 16) - WIN_BASE;
  endfunction

  // One add per access: CPU address plus stored offset.
  function automatic logic [31:0] map_address(input logic [31:0] addr,
                                              input logic [31:0] offset);
    return addr + offset;
  endfunction

  function automatic logic beyond_window(input logic [31:0] addr);
    return addr >= WIN_LIMIT;
  endfunction

endpackage

// File: rtl/bankwin_offset_reg.sv
module bankwin_offset_reg
  import bankwin_pkg::*;
#(
  parameter int VRAM_BYTES = 1 << 20,
  parameter int BANK_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_val,
  input  logic              bank_we,
  input  logic              win_disable,
  output logic [31:0]       offset
);

  localparam int BANK_COUNT = VRAM_BYTES / 65536;
  localparam logic [BANK_W-1:0] BANK_MASK = BANK_W'(BANK_COUNT - 1);

  logic [BANK_W-1:0] masked_bank;
  assign masked_bank = bank_val & BANK_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= bank_offset(32'd0);
    end else if (win_disable) begin
      offset <= bank_offset(32'd0);
    end else if (bank_we) begin
      offset <= bank_offset(32'(masked_bank));
    end
  end

endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode
  import bankwin_pkg::*;
#(
  parameter int CPU_AW  = 20,
  parameter int VADDR_W = 20,
  parameter int DW      = 8
) (
  input  logic               map_en,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [31:0]        offset,
  output logic [VADDR_W-1:0] vm_addr,
  output logic               vm_rd,
  output logic               vm_wr,
  output logic [DW-1:0]      vm_wdata,
  output logic               rd_accept,
  output logic               rd_blocked
);

  logic outside;
  assign outside    = beyond_window(32'(cpu_addr));
  assign vm_addr    = VADDR_W'(map_address(32'(cpu_addr), offset));
  assign vm_wdata   = cpu_wdata;
  assign rd_accept  = map_en && cpu_rd;
  assign rd_blocked = rd_accept && outside;
  assign vm_rd      = rd_accept && !outside;
  assign vm_wr      = map_en && cpu_wr && !outside;

endmodule

// File: rtl/bankwin_rdresp.sv
module bankwin_rdresp #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_accept,
  input  logic          rd_blocked,
  input  logic [DW-1:0] vm_rdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_rvalid
);

  logic blocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_rvalid <= 1'b0;
      blocked_q  <= 1'b0;
    end else begin
      cpu_rvalid <= rd_accept;
      blocked_q  <= rd_blocked;
    end
  end

  assign cpu_rdata = blocked_q ? {DW{1'b1}} : vm_rdata;

endmodule

// File: rtl/bankwin_mapper.sv
module bankwin_mapper #(
  parameter int CPU_AW     = 20,
  parameter int VRAM_BYTES = 1 << 20,
  parameter int DW         = 8,
  parameter int BANK_W     = 16,
  localparam int VADDR_W   = $clog2(VRAM_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               map_en,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_rd,
  input  logic               cpu_wr,
  input  logic [DW-1:0]      cpu_wdata,
  input  logic [BANK_W-1:0]  bank_val,
  input  logic               bank_we,
  input  logic               win_disable,
  output logic [VADDR_W-1:0] vm_addr,
  output logic               vm_rd,
  output logic               vm_wr,
  output logic [DW-1:0]      vm_wdata,
  input  logic [DW-1:0]      vm_rdata,
  output logic [DW-1:0]      cpu_rdata,
  output logic               cpu_rvalid
);

  logic [31:0] win_offset;
  logic        rd_accept;
  logic        rd_blocked;

  bankwin_offset_reg #(
    .VRAM_BYTES(VRAM_BYTES),
    .BANK_W    (BANK_W)
  ) u_offset (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_val   (bank_val),
    .bank_we    (bank_we),
    .win_disable(win_disable),
    .offset     (win_offset)
  );

  bankwin_decode #(
    .CPU_AW (CPU_AW),
    .VADDR_W(VADDR_W),
    .DW     (DW)
  ) u_decode (
    .map_en    (map_en),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .offset    (win_offset),
    .vm_addr   (vm_addr),
    .vm_rd     (vm_rd),
    .vm_wr     (vm_wr),
    .vm_wdata  (vm_wdata),
    .rd_accept (rd_accept),
    .rd_blocked(rd_blocked)
  );

  bankwin_rdresp #(
    .DW(DW)
  ) u_rdresp (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_accept (rd_accept),
    .rd_blocked(rd_blocked),
    .vm_rdata  (vm_rdata),
    .cpu_rdata (cpu_rdata),
    .cpu_rvalid(cpu_rvalid)
  );

endmodule

// File: rtl/bankwin_mapper_chk.sv
module bankwin_mapper_chk #(
  parameter int CPU_AW     = 20,
  parameter int VRAM_BYTES = 1 << 20,
  parameter int DW         = 8,
  parameter int BANK_W     = 16,
  parameter int VADDR_W    = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               map_en,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic               cpu_rd,
  input logic               cpu_wr,
  input logic [DW-1:0]      cpu_wdata,
  input logic [BANK_W-1:0]  bank_val,
  input logic               bank_we,
  input logic               win_disable,
  input logic [VADDR_W-1:0] vm_addr,
  input logic               vm_rd,
  input logic               vm_wr,
  input logic [DW-1:0]      vm_wdata,
  input logic [DW-1:0]      vm_rdata,
  input logic [DW-1:0]      cpu_rdata,
  input logic               cpu_rvalid
);

  localparam logic [31:0] MASK32 = 32'(VRAM_BYTES / 65536 - 1);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  logic high_addr;
  assign high_addr = 32'(cpu_addr) >= 32'h000B_0000;

  AST_BLOCKED_RD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    map_en && cpu_rd && high_addr |-> !vm_rd); // R5

  AST_BLOCKED_RD_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    map_en && cpu_rd && high_addr |=> cpu_rvalid && cpu_rdata == {DW{1'b1}}); // R5

  AST_BLOCKED_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    map_en && cpu_wr && high_addr |-> !vm_wr); // R6

  AST_WDATA_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    vm_wr |-> vm_wdata == cpu_wdata); // R4

  AST_RD_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    vm_rd |=> cpu_rvalid && cpu_rdata == vm_rdata); // R7

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |-> !vm_rd && !vm_wr); // R9

  AST_NO_VALID_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !map_en |=> !cpu_rvalid); // R9

  AST_DISABLE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(win_disable) |->
      vm_addr == VADDR_W'(32'(cpu_addr) - 32'h000A_0000)); // R8

  AST_BANK_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(bank_we) && !$past(win_disable) |->
      vm_addr == VADDR_W'(32'(cpu_addr) + ((32'($past(bank_val)) & MASK32) << 16)
                          - 32'h000A_0000)); // R2

endmodule

bind bankwin_mapper bankwin_mapper_chk #(
  .CPU_AW    (CPU_AW),
  .VRAM_BYTES(VRAM_BYTES),
  .DW        (DW),
  .BANK_W    (BANK_W),
  .VADDR_W   (VADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .map_en     (map_en),
  .cpu_addr   (cpu_addr),
  .cpu_rd     (cpu_rd),
  .cpu_wr     (cpu_wr),
  .cpu_wdata  (cpu_wdata),
  .bank_val   (bank_val),
  .bank_we    (bank_we),
  .win_disable(win_disable),
  .vm_addr    (vm_addr),
  .vm_rd      (vm_rd),
  .vm_wr      (vm_wr),
  .vm_wdata   (vm_wdata),
  .vm_rdata   (vm_rdata),
  .cpu_rdata  (cpu_rdata),
  .cpu_rvalid (cpu_rvalid)
);

// File: tb/bankwin_mapper_test.sv
module bankwin_mapper_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        map_en = 1'b1;
  logic [19:0] cpu_addr = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [15:0] bank_val = '0;
  logic        bank_we = 1'b0;
  logic        win_disable = 1'b0;
  logic [19:0] vm_addr;
  logic        vm_rd, vm_wr;
  logic [7:0]  vm_wdata, vm_rdata, cpu_rdata;
  logic        cpu_rvalid;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bankwin_mapper uut (
    .clk(clk), .rst_n(rst_n), .map_en(map_en), .cpu_addr(cpu_addr),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .bank_val(bank_val), .bank_we(bank_we), .win_disable(win_disable),
    .vm_addr(vm_addr), .vm_rd(vm_rd), .vm_wr(vm_wr), .vm_wdata(vm_wdata),
    .vm_rdata(vm_rdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid)
  );

  function automatic logic [7:0] pattern(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
  endfunction

  // Memory model: data for the address of a read appears one cycle later.
  logic [7:0] mem_q = '0;
  always @(posedge clk) if (vm_rd) mem_q <= pattern(vm_addr);
  assign vm_rdata = mem_q;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_bank(input logic [15:0] b);
    @(negedge clk); bank_val = b; bank_we = 1'b1;
    @(negedge clk); bank_we = 1'b0;
  endtask

  task automatic do_read(input logic [19:0] a, input logic [31:0] off);
    logic blocked;
    logic [19:0] ea;
    @(negedge clk); cpu_addr = a; cpu_rd = 1'b1; #1;
    blocked = a >= 20'hB0000;
    ea = 20'(32'(a) + off);
    chk(blocked ? "R5 vm_rd" : "R7 vm_rd", 32'(vm_rd), 32'(!blocked));
    if (!blocked) chk("R4 read address", 32'(vm_addr), 32'(ea));
    @(negedge clk); cpu_rd = 1'b0;
    chk("R7 cpu_rvalid", 32'(cpu_rvalid), 32'd1);
    if (blocked) chk("R5 all-ones data", 32'(cpu_rdata), 32'hFF);
    else         chk("R7 read data", 32'(cpu_rdata), 32'(pattern(ea)));
  endtask

  task automatic do_write(input logic [19:0] a, input logic [31:0] off);
    logic blocked;
    @(negedge clk); cpu_addr = a; cpu_wr = 1'b1; cpu_wdata = a[7:0] ^ 8'h3C; #1;
    blocked = a >= 20'hB0000;
    chk(blocked ? "R6 vm_wr" : "R4 vm_wr", 32'(vm_wr), 32'(!blocked));
    if (!blocked) begin
      chk("R4 write address", 32'(vm_addr), 32'(20'(32'(a) + off)));
      chk("R4 write data", 32'(vm_wdata), 32'(a[7:0] ^ 8'h3C));
    end
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  localparam logic [19:0] ADDRS [8] = '{20'hA0000, 20'hA0001, 20'hA7FFF, 20'hA5A5A,
                                        20'hAFFFF, 20'hB0000, 20'hB1234, 20'hFFFFF};

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); cpu_addr = 20'hA0000; #1;
    chk("R1 reset offset", 32'(vm_addr), 32'h0);
    chk("R1 rvalid low", 32'(cpu_rvalid), 32'h0);
    do_read(20'hA1234, 32'hFFF6_0000); // R1: bank zero before any bank write

    // R2 R3: sweep bank numbers past the memory size
    for (int b = 0; b < 32; b++) begin
      logic [31:0] off;
      set_bank(16'(b));
      off = ((32'(b) & 32'hF) << 16) - 32'h000A_0000;
      for (int i = 0; i < 8; i++) begin
        do_read(ADDRS[i], off);
        do_write(ADDRS[i], off);
      end
    end

    // R2 timing: the new bank is not in effect during the write cycle itself
    set_bank(16'd2);
    @(negedge clk); bank_val = 16'd9; bank_we = 1'b1; cpu_addr = 20'hA0010; #1;
    chk("R2 old offset in write cycle", 32'(vm_addr), 32'h20010);
    @(negedge clk); bank_we = 1'b0; #1;
    chk("R2 new offset next cycle", 32'(vm_addr), 32'h90010);

    // R8: disable wins over a simultaneous bank write
    set_bank(16'd5);
    @(negedge clk); bank_val = 16'd7; bank_we = 1'b1; win_disable = 1'b1;
    @(negedge clk); bank_we = 1'b0; win_disable = 1'b0; cpu_addr = 20'hA1234; #1;
    chk("R8 disable restores bank zero", 32'(vm_addr), 32'h01234);

    // R9: mode off
    set_bank(16'd3);
    @(negedge clk); map_en = 1'b0; cpu_addr = 20'hA0100; cpu_rd = 1'b1; cpu_wr = 1'b1; #1;
    chk("R9 no vm_rd", 32'(vm_rd), 32'h0);
    chk("R9 no vm_wr", 32'(vm_wr), 32'h0);
    @(negedge clk); cpu_rd = 1'b0; cpu_wr = 1'b0;
    chk("R9 no cpu_rvalid", 32'(cpu_rvalid), 32'h0);
    map_en = 1'b1;
    do_read(20'hA0100, 32'h0003_0000 - 32'h000A_0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule